// File: doc/BRIEF.md
# ATA PIO and Multiword DMA Strobe Sequencer

This block turns single transfer requests into read and write strobe waveforms on one parallel ATA channel. It covers programmed I/O data transfers, task-file register accesses and multiword DMA transfers. A 32-bit timing word sets the length of each phase. Task-file accesses take their lengths from one group of fields in the word. Data and DMA transfers take theirs from a second group.

Each access runs through up to three phases. First comes an optional setup phase, in which the chip select and address are already driven. Next is the active phase, in which the strobe is asserted. Last is the recovery phase, in which the strobe is released but the chip select is still held. The host side offers a request with valid/ready. Ready is high only while the sequencer is idle, so back-pressure is one request at a time. A request is taken on the edge where valid and ready are both high. The request fields must be stable in that cycle. The response is a one-clock done pulse, with read data alongside it. The response side has no ready and cannot be held off. The timing word must stay stable while an access is in progress.

Top module: `ata_pio_strobe_gen`

## Requirements
- R1: While reset is asserted and right after it, dior_n, diow_n, cs0_n, cs1_n and dmack_n are high. dd_oe and done are low, req_ready is high and rd_data is zero.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both high. req_ready is high only while idle. It stays low from the cycle after acceptance through the last recovery cycle.
- R3: A data or DMA access takes its setup length from word bits 24:22, its active length from bits 8:4 and its recovery length from bits 3:0. Each phase lasts its field value plus one clock.
- R4: A task-file access (req_cmd=1) takes its setup length from bits 27:25, its active length from bits 17:13 and its recovery length from bits 12:9. Each phase lasts its field value plus one clock. When req_cmd=1, req_dma is ignored.
- R5: During the active phase, dior_n is low for a read (req_write=0) and diow_n is low for a write. The two are never low together, and both are high in every other phase.
- R6: The setup phase is skipped only for a request that meets two conditions. It is accepted in the first cycle after a done pulse, and it has the same class as the previous access. There are two classes: task-file, and data-or-DMA. Any other request starts with setup.
- R7: For a read, rd_data takes dd_in on the edge that ends the active phase. rd_data then holds until the next read captures.
- R8: done is high for exactly one clock, in the last recovery cycle of every access that was not discarded.
- R9: A task-file access drives da = req_addr[2:0], and req_addr[3] selects cs1_n (1) or cs0_n (0). A PIO data access drives cs0_n low with da = 0. The chip select and da hold from the first setup cycle to the last recovery cycle. Both chip selects are high when idle.
- R10: A DMA access (req_cmd=0, req_dma=1) drives dmack_n low instead of a chip select, with da = 0, for its whole duration.
- R11: When word bit 29 is clear, a DMA request is accepted and discarded. No strobe, select or done follows, and req_ready stays high.
- R12: A write drives req_wdata on dd_out with dd_oe high from the first setup cycle to the last recovery cycle. dd_oe is low for reads and when idle.
- R13: Word bits 18 to 21, 28, 30 and 31 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tword | input | 32 | Timing word, held stable during an access |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_cmd | input | 1 | 1 = task-file register access |
| req_dma | input | 1 | 1 = multiword DMA transfer (when req_cmd=0) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | DA_W+1 | Bit DA_W selects the control block; the low bits give the register |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-clock end-of-access pulse |
| rd_data | output | DATA_W | Last captured read data |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| cs0_n | output | 1 | Command block select, active low |
| cs1_n | output | 1 | Control block select, active low |
| dmack_n | output | 1 | DMA acknowledge, active low |
| da | output | DA_W | Device register address |
| dd_out | output | DATA_W | Data driven toward the device |
| dd_oe | output | 1 | Output enable for dd_out |
| dd_in | input | DATA_W | Data returned by the device |

## Verification
The properties assume three things about the inputs. The timing word changes only while the sequencer is idle. A request's fields are valid in the cycle it is offered. Outside reset, the only way an access starts is through a valid/ready handshake. The stimulus obeys these assumptions. It changes the word and drives request fields only in idle cycles, on the falling edge, and it drops valid when the handshake is not possible. Stimulus and timing words cover four cases: zero-length, full-length and mixed field values, and words that set the ignored bits.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACTIVE = 2'd2,
    PH_RECOV  = 2'd3
  } phase_e;

  localparam int TW_W  = 32;
  localparam int SET_W = 3;
  localparam int ACT_W = 5;
  localparam int REC_W = 4;
  localparam int CNT_W = (ACT_W > REC_W) ? ((ACT_W > SET_W) ? ACT_W : SET_W)
                                         : ((REC_W > SET_W) ? REC_W : SET_W);

  // class index: 0 = data / DMA, 1 = task-file
  localparam int NCLS = 2;
  localparam int REC_LSB [NCLS] = '{0, 9};
  localparam int ACT_LSB [NCLS] = '{4, 13};
  localparam int SET_LSB [NCLS] = '{22, 25};
  localparam int DMA_EN_BIT = 29;

  typedef struct packed {
    logic [SET_W-1:0] setup;
    logic [ACT_W-1:0] act;
    logic [REC_W-1:0] rec;
  } phase_len_t;

endpackage

// File: rtl/ata_tword_decode.sv
module ata_tword_decode
  import ata_strobe_pkg::*;
(
  input  logic [TW_W-1:0] tword,
  input  logic            cls,
  output phase_len_t      len,
  output logic            dma_en
);

  phase_len_t lens [NCLS];

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign lens[c].setup = tword[SET_LSB[c] +: SET_W];
    assign lens[c].act   = tword[ACT_LSB[c] +: ACT_W];
    assign lens[c].rec   = tword[REC_LSB[c] +: REC_W];
  end

  assign len    = lens[cls];
  assign dma_en = tword[DMA_EN_BIT];

endmodule

// File: rtl/ata_phase_timer.sv
module ata_phase_timer #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/ata_strobe_fsm.sv
module ata_strobe_fsm
  import ata_strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             same_cls,
  input  phase_len_t       len,
  input  logic             zero,
  output phase_e           phase,
  output logic             ready,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             done,
  output logic             capture
);

  phase_e nxt;
  logic   follow_q;   // previous cycle carried a done pulse

  always_comb begin
    nxt      = phase;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase)
      PH_IDLE: if (take) begin
        tmr_load = 1'b1;
        if (follow_q && same_cls) begin
          nxt     = PH_ACTIVE;
          tmr_val = CNT_W'(len.act);
        end else begin
          nxt     = PH_SETUP;
          tmr_val = CNT_W'(len.setup);
        end
      end
      PH_SETUP: if (zero) begin
        nxt      = PH_ACTIVE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(len.act);
      end
      PH_ACTIVE: if (zero) begin
        nxt      = PH_RECOV;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(len.rec);
      end
      PH_RECOV: if (zero) nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      follow_q <= 1'b0;
    end else begin
      phase    <= nxt;
      follow_q <= done;
    end
  end

  assign ready   = (phase == PH_IDLE);
  assign done    = (phase == PH_RECOV)  && zero;
  assign capture = (phase == PH_ACTIVE) && zero;

endmodule

// File: rtl/ata_pio_strobe_gen.sv
module ata_pio_strobe_gen
  import ata_strobe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DA_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW_W-1:0]   tword,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_cmd,
  input  logic              req_dma,
  input  logic              req_write,
  input  logic [DA_W:0]     req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              dior_n,
  output logic              diow_n,
  output logic              cs0_n,
  output logic              cs1_n,
  output logic              dmack_n,
  output logic [DA_W-1:0]   da,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  input  logic [DATA_W-1:0] dd_in
);

  localparam int ADDR_W = DA_W + 1;

  phase_e           phase;
  phase_len_t       len;
  logic             dma_en, accept, drop, take, cls_sel, zero;
  logic             tmr_load, capture, busy, active;
  logic [CNT_W-1:0] tmr_val;

  logic              cur_cmd, cur_dma, cur_wr;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;

  assign accept  = req_valid && req_ready;
  assign drop    = req_dma && !req_cmd && !dma_en;
  assign take    = accept && !drop;
  assign cls_sel = (phase == PH_IDLE) ? req_cmd : cur_cmd;

  ata_tword_decode u_dec (
    .tword  (tword),
    .cls    (cls_sel),
    .len    (len),
    .dma_en (dma_en)
  );

  ata_phase_timer #(.CW(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (zero)
  );

  ata_strobe_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .same_cls (req_cmd == cur_cmd),
    .len      (len),
    .zero     (zero),
    .phase    (phase),
    .ready    (req_ready),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .done     (done),
    .capture  (capture)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_cmd   <= 1'b0;
      cur_dma   <= 1'b0;
      cur_wr    <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
    end else if (take) begin
      cur_cmd   <= req_cmd;
      cur_dma   <= req_dma && !req_cmd;
      cur_wr    <= req_write;
      cur_addr  <= req_addr;
      cur_wdata <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  rd_data <= '0;
    else if (capture && !cur_wr) rd_data <= dd_in;
  end

  assign busy    = (phase != PH_IDLE);
  assign active  = (phase == PH_ACTIVE);
  assign dior_n  = !(active && !cur_wr);
  assign diow_n  = !(active && cur_wr);
  assign dmack_n = !(busy && cur_dma);
  assign cs0_n   = !(busy && !cur_dma && !(cur_cmd && cur_addr[DA_W]));
  assign cs1_n   = !(busy && !cur_dma && cur_cmd && cur_addr[DA_W]);
  assign da      = (busy && cur_cmd) ? cur_addr[DA_W-1:0] : '0;
  assign dd_out  = cur_wdata;
  assign dd_oe   = busy && cur_wr;

endmodule

// File: rtl/ata_pio_strobe_chk.sv
module ata_pio_strobe_chk
  import ata_strobe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DA_W   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic [TW_W-1:0] tword,
  input logic            req_valid,
  input logic            req_ready,
  input logic            req_cmd,
  input logic            req_dma,
  input logic            done,
  input logic            dior_n,
  input logic            diow_n,
  input logic            cs0_n,
  input logic            cs1_n,
  input logic            dmack_n,
  input logic [DA_W-1:0] da,
  input logic            dd_oe
);

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n));

  // R2
  busy_noready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n || !diow_n || !cs0_n || !cs1_n || !dmack_n) |-> !req_ready);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_in_recov_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dior_n && diow_n && !req_ready));

  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs0_n && $past(!cs0_n)) || (!cs1_n && $past(!cs1_n)) |-> $stable(da));

  // R10
  ack_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dmack_n |-> (cs0_n && cs1_n));

  // R12
  oe_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> dior_n);

  // R11
  dma_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_dma && !req_cmd && !tword[DMA_EN_BIT])
      |=> (req_ready && dmack_n && !done));

endmodule

bind ata_pio_strobe_gen ata_pio_strobe_chk #(.DATA_W(DATA_W), .DA_W(DA_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tword     (tword),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_cmd   (req_cmd),
  .req_dma   (req_dma),
  .done      (done),
  .dior_n    (dior_n),
  .diow_n    (diow_n),
  .cs0_n     (cs0_n),
  .cs1_n     (cs1_n),
  .dmack_n   (dmack_n),
  .da        (da),
  .dd_oe     (dd_oe)
);

// File: tb/test_ata_pio_strobe_gen.sv
module test_ata_pio_strobe_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tword = '0;
  logic        req_valid = 1'b0, req_cmd = 1'b0, req_dma = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [15:0] req_wdata = '0, dd_in = 16'h0101;
  logic        req_ready, done, dior_n, diow_n, cs0_n, cs1_n, dmack_n, dd_oe;
  logic [15:0] rd_data, dd_out;
  logic [2:0]  da;

  always #5 clk = ~clk;

  ata_pio_strobe_gen i_ata_pio_strobe_gen (.*);

  typedef struct {
    logic rdn, wrn, cs0n, cs1n, ackn, oe, dn, lastact, isrd;
    logic [2:0] da;
    string tag;
  } exp_t;

  typedef struct {
    logic cmd, dma, wr;
    logic [3:0] addr;
    logic [15:0] wdata;
    logic [31:0] tw;
    int gap;
    string tag;
  } rq_t;

  exp_t q[$];
  rq_t  rl[$];
  int   total = 0, bad = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h time=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_tw(int ds, int dact, int dr, int cs, int ca, int cr,
                                        bit dma, bit extra);
    logic [31:0] w = '0;
    w[3:0] = 4'(dr);  w[8:4] = 5'(dact);  w[24:22] = 3'(ds);
    w[12:9] = 4'(cr); w[17:13] = 5'(ca); w[27:25] = 3'(cs);
    w[29] = dma;
    if (extra) begin w[31] = 1'b1; w[30] = 1'b1; w[28] = 1'b1; w[21:18] = 4'hF; end
    return w;
  endfunction

  task automatic add(bit cmd, bit dma, bit wr, logic [3:0] addr, logic [15:0] wd,
                     logic [31:0] tw, int gap, string tag);
    rq_t r;
    r.cmd = cmd; r.dma = dma; r.wr = wr; r.addr = addr; r.wdata = wd;
    r.tw = tw; r.gap = gap; r.tag = tag;
    rl.push_back(r);
  endtask

  task automatic push_seq(rq_t r, bit skip_setup);
    exp_t e;
    int s, a, rc;
    bit dmac = r.dma && !r.cmd;
    s  = r.cmd ? int'(r.tw[27:25]) : int'(r.tw[24:22]);
    a  = r.cmd ? int'(r.tw[17:13]) : int'(r.tw[8:4]);
    rc = r.cmd ? int'(r.tw[12:9])  : int'(r.tw[3:0]);
    e.tag  = skip_setup ? "R6" : r.tag;
    e.ackn = !dmac;
    e.cs0n = dmac || (r.cmd && r.addr[3]);
    e.cs1n = !(!dmac && r.cmd && r.addr[3]);
    e.da   = r.cmd ? r.addr[2:0] : 3'd0;
    e.oe   = r.wr; e.isrd = !r.wr; e.dn = 1'b0; e.lastact = 1'b0;
    e.rdn = 1'b1; e.wrn = 1'b1;
    if (!skip_setup) for (int k = 0; k <= s; k++) q.push_back(e);
    e.rdn = r.wr; e.wrn = !r.wr;
    for (int k = 0; k <= a; k++) begin e.lastact = (k == a); q.push_back(e); end
    e.rdn = 1'b1; e.wrn = 1'b1; e.lastact = 1'b0;
    for (int k = 0; k <= rc; k++) begin e.dn = (k == rc); q.push_back(e); end
  endtask

  initial begin
    logic [31:0] twa, twz, twm, twx, twn;
    exp_t e, idle_e;
    int cyc = 0, idle_run = 0, nxt = 0;
    bit prev_done = 0, last_cmd = 0, was_idle;
    logic [15:0] exp_rd = '0, cur_wd = '0;
    string idle_tag = "R2";

    twa = mk_tw(1, 3, 2, 2, 5, 3, 1, 0);
    twz = mk_tw(0, 0, 0, 0, 0, 0, 1, 0);
    twm = mk_tw(7, 31, 15, 7, 31, 15, 1, 0);
    twx = mk_tw(1, 3, 2, 2, 5, 3, 1, 1);
    twn = mk_tw(1, 3, 2, 2, 5, 3, 0, 0);
    add(0, 0, 0, 4'h0, 16'h0,    twa, 2, "R3");
    add(0, 0, 1, 4'h0, 16'hA5A5, twa, 2, "R12");
    add(1, 0, 0, 4'h7, 16'h0,    twa, 1, "R4");
    add(1, 0, 1, 4'hE, 16'h3C3C, twa, 1, "R9");
    add(0, 0, 0, 4'h0, 16'h0,    twa, 0, "R3");
    add(0, 0, 0, 4'h0, 16'h0,    twa, 0, "R6");
    add(0, 0, 1, 4'h0, 16'h1234, twa, 0, "R6");
    add(1, 0, 0, 4'h2, 16'h0,    twa, 0, "R6");
    add(1, 0, 1, 4'h9, 16'h5678, twa, 0, "R6");
    add(0, 1, 0, 4'h0, 16'h0,    twa, 1, "R10");
    add(0, 1, 1, 4'h0, 16'h9ABC, twa, 0, "R10");
    add(0, 1, 0, 4'h0, 16'h0,    twn, 2, "R11");
    add(0, 0, 0, 4'h0, 16'h0,    twn, 0, "R11");
    add(0, 0, 0, 4'h0, 16'h0,    twz, 1, "R3");
    add(1, 0, 1, 4'h5, 16'h0F0F, twz, 1, "R4");
    add(0, 0, 0, 4'h0, 16'h0,    twm, 1, "R3");
    add(1, 0, 0, 4'hB, 16'h0,    twm, 1, "R4");
    add(0, 0, 1, 4'h0, 16'hBEEF, twx, 1, "R13");
    add(1, 0, 0, 4'h3, 16'h0,    twx, 1, "R13");
    add(1, 1, 0, 4'h4, 16'h0,    twa, 1, "R4");
    for (int j = 0; j < 24; j++)
      add(j % 3 == 1, j % 5 == 2, j % 2 == 0, 4'(j * 5), 16'(j * 4099 + 7),
          mk_tw(j % 8, (j * 7) % 32, (j * 3) % 16, (j * 5) % 8, (j * 11) % 32, (j * 13) % 16,
                j % 4 != 3, j % 6 == 0),
          j % 3, "R13");

    idle_e.rdn = 1; idle_e.wrn = 1; idle_e.cs0n = 1; idle_e.cs1n = 1; idle_e.ackn = 1;
    idle_e.oe = 0; idle_e.dn = 0; idle_e.lastact = 0; idle_e.isrd = 0; idle_e.da = 3'd0;

    // reset state
    repeat (3) @(negedge clk);
    chk("R1", "dior_n", 32'(dior_n), 1);  chk("R1", "diow_n", 32'(diow_n), 1);
    chk("R1", "cs0_n", 32'(cs0_n), 1);    chk("R1", "cs1_n", 32'(cs1_n), 1);
    chk("R1", "dmack_n", 32'(dmack_n), 1); chk("R1", "dd_oe", 32'(dd_oe), 0);
    chk("R1", "done", 32'(done), 0);      chk("R1", "req_ready", 32'(req_ready), 1);
    chk("R1", "rd_data", 32'(rd_data), 0);
    rst_n = 1'b1;

    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 60000) begin
        bad++; total++;
        $display("FAIL watchdog: run did not finish");
        break;
      end
      was_idle = (q.size() == 0);
      if (was_idle) begin e = idle_e; e.tag = idle_tag; end
      else e = q.pop_front();
      chk("R2", "req_ready", 32'(req_ready), 32'(was_idle));
      chk(e.tag, "dior_n", 32'(dior_n), 32'(e.rdn));
      chk(e.tag, "diow_n", 32'(diow_n), 32'(e.wrn));
      chk(e.ackn ? "R9" : "R10", "cs0_n", 32'(cs0_n), 32'(e.cs0n));
      chk(e.ackn ? "R9" : "R10", "cs1_n", 32'(cs1_n), 32'(e.cs1n));
      chk("R9", "da", 32'(da), 32'(e.da));
      chk("R10", "dmack_n", 32'(dmack_n), 32'(e.ackn));
      chk("R12", "dd_oe", 32'(dd_oe), 32'(e.oe));
      if (e.oe) chk("R12", "dd_out", 32'(dd_out), 32'(cur_wd));
      chk("R8", "done", 32'(done), 32'(e.dn));
      chk("R7", "rd_data", 32'(rd_data), 32'(exp_rd));

      req_valid = 1'b0;
      idle_tag = "R2";
      if (was_idle) idle_run++; else idle_run = 0;
      if (was_idle && nxt < rl.size() && idle_run > rl[nxt].gap) begin
        rq_t r = rl[nxt];
        nxt++;
        req_valid = 1'b1; req_cmd = r.cmd; req_dma = r.dma; req_write = r.wr;
        req_addr = r.addr; req_wdata = r.wdata; tword = r.tw;
        if (r.dma && !r.cmd && !r.tw[29]) idle_tag = "R11";
        else begin
          push_seq(r, prev_done && (r.cmd == last_cmd));
          last_cmd = r.cmd;
          cur_wd = r.wdata;
        end
        idle_run = 0;
      end
      prev_done = e.dn;
      dd_in = dd_in * 16'd5 + 16'h1357;
      if (e.lastact && e.isrd) exp_rd = dd_in;
      if (nxt >= rl.size() && q.size() == 0 && idle_run > 4) break;
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule